// File: doc/BRIEF.md
# Link Reply Status Classifier

When a request on the display link's auxiliary channel has been sent, the receiver sets a group of status flags and fills a reply buffer. This block turns that raw outcome into one verdict. It holds a small byte buffer for the reply while the transaction is in flight. When the transaction closes it decides, in a fixed priority order, what happened. The possible verdicts are a hot-plug loss, a timeout, a malformed reply, a reply too large for the caller, or a usable reply. For a usable reply it reports the 4-bit reply command and the number of data bytes.

The caller starts each transaction with a `start` pulse. It then feeds the received bytes on `rx_byte_vld`/`rx_byte` and raises `st_done` together with the status flags once the receiver has finished. If the receiver never raises `st_done`, the block closes the transaction itself after a fixed polling window. The data bytes of an acknowledged reply are replayed from the buffer on `dout_vld`/`dout_byte`/`dout_idx`, and only then does the verdict become valid. The verdict stays on the outputs until the next `start`.

Top module: `aux_reply_classifier`

## Requirements
- R1: If `st_unplug` is high when the transaction closes, the verdict is 3 (unplugged), whatever `st_done` and the other flags are. A high `st_unplug` closes the transaction by itself.
- R2: If neither `st_done` nor `st_unplug` is seen within POLL_CYCLES cycles after `start`, the verdict is 1 (timeout).
- R3: With `st_done` high, either `st_tmo_live` or `st_tmo_seen` gives verdict 1 (timeout), even when receive-error flags are also set.
- R4: With `st_done` high and no timeout flag, any of `st_bad_stop`, `st_no_edge`, `st_bad_high` or `st_bad_low` gives verdict 2 (invalid). `st_min_viol` has no effect on the verdict.
- R5: A clean completion with `st_rx_cnt` equal to 0 gives verdict 2 (invalid). Otherwise `data_cnt` is `st_rx_cnt` minus one.
- R6: On a clean completion, `reply_cmd` is bits 7:4 of the first received byte. For any verdict other than 0 (success) or 4 (overflow), `reply_cmd` and `data_cnt` read 0.
- R7: Data bytes (received bytes 1 onward) are replayed in order with `dout_idx` counting up from 0, and only when `reply_cmd` is 0. A nonzero reply command gives verdict 0 with no bytes replayed.
- R8: An acknowledged reply whose data count exceeds `cap_bytes` or DEPTH-1 gives verdict 4 (overflow), and no byte is replayed. A count equal to `cap_bytes` is accepted.
- R9: `res_vld` rises after the last replayed byte, or one cycle after closing when nothing is replayed. The verdict, `reply_cmd` and `data_cnt` hold steady while `res_vld` is high, and `res_vld` drops in the cycle after `start`.
- R10: After reset `res_vld`, `dout_vld` and `res_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a transaction (taken when idle) |
| rx_byte_vld | input | 1 | A received reply byte is present |
| rx_byte | input | 8 | Received reply byte, header first |
| st_done | input | 1 | Receiver finished |
| st_unplug | input | 1 | Hot-plug lost |
| st_tmo_live | input | 1 | Receiver in timeout state |
| st_tmo_seen | input | 1 | Receiver timed out |
| st_bad_stop | input | 1 | Invalid stop condition |
| st_no_edge | input | 1 | Reply not detected |
| st_bad_high | input | 1 | Invalid high level |
| st_bad_low | input | 1 | Invalid low level |
| st_min_viol | input | 1 | Minimum-count violation (ignored) |
| st_rx_cnt | input | CNT_W | Received byte count, header included |
| cap_bytes | input | CNT_W | Caller buffer size in data bytes |
| res_vld | output | 1 | Verdict valid |
| res_code | output | 3 | 0 ok, 1 timeout, 2 invalid, 3 unplugged, 4 overflow |
| reply_cmd | output | 4 | Reply command nibble |
| data_cnt | output | CNT_W | Data byte count |
| dout_vld | output | 1 | Replayed data byte valid |
| dout_byte | output | 8 | Replayed data byte |
| dout_idx | output | AW | Index of replayed byte |

## Verification
The hardest case to reach from the ports is a poll-window expiry. It needs a transaction in which neither `st_done` nor `st_unplug` ever rises, so the stimulus sends the reply bytes and then leaves both low until the block closes the transaction itself. The priority order is checked by stacking several flags in one closing cycle: unplug with timeout, timeout with every receive error, and `st_min_viol` alone on an otherwise clean acknowledged reply. The overflow limit is approached from both sides: a data count equal to `cap_bytes`, one above it, one above the buffer depth, and an oversized reply carrying a nonzero command, which must not overflow.

// File: rtl/aux_cls_pkg.sv
package aux_cls_pkg;
  typedef enum logic [2:0] {
    RES_OK     = 3'd0,
    RES_TMO    = 3'd1,
    RES_BAD    = 3'd2,
    RES_UNPLUG = 3'd3,
    RES_OVF    = 3'd4
  } aux_res_e;
endpackage

// File: rtl/aux_rx_buffer.sv
module aux_rx_buffer #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);
  // single write port, registered read: block RAM friendly
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_q <= mem[ra];
  end

  assign rd = rd_q;
endmodule

// File: rtl/aux_status_judge.sv
module aux_status_judge
  import aux_cls_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             unplug,
  input  logic             done,
  input  logic             tmo_a,
  input  logic             tmo_b,
  input  logic             e_stop,
  input  logic             e_nodet,
  input  logic             e_hi,
  input  logic             e_lo,
  input  logic [CNT_W-1:0] cnt,
  input  logic [3:0]       hdr_hi,
  input  logic [CNT_W-1:0] cap,
  output aux_res_e         res,
  output logic [3:0]       code,
  output logic [CNT_W-1:0] dcnt,
  output logic             fwd
);
  localparam int ROOM = DEPTH - 1;
  logic [CNT_W-1:0] dc;

  // fixed priority: unplug, no completion, timeout, receive error, empty
  always_comb begin
    res  = RES_OK;
    code = '0;
    dcnt = '0;
    fwd  = 1'b0;
    dc   = cnt - 1'b1;
    if (unplug)                             res = RES_UNPLUG;
    else if (!done)                         res = RES_TMO;
    else if (tmo_a || tmo_b)                res = RES_TMO;
    else if (e_stop || e_nodet || e_hi || e_lo) res = RES_BAD;
    else if (cnt == '0)                     res = RES_BAD;
    else begin
      code = hdr_hi;
      dcnt = dc;
      if (hdr_hi == 4'd0) begin
        if (dc > cap || int'(dc) > ROOM) res = RES_OVF;
        else fwd = 1'b1;
      end
    end
  end
endmodule

// File: rtl/aux_byte_sender.sv
module aux_byte_sender #(
  parameter int AW    = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] n,
  output logic [AW-1:0]    rd_addr,
  output logic             out_vld,
  output logic [AW-1:0]    out_idx,
  output logic             last
);
  logic          act;
  logic [AW-1:0] idx, n_r, idx_q;
  logic          vld_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0; idx <= '0; n_r <= '0;
      vld_q <= 1'b0; idx_q <= '0; last_q <= 1'b0;
    end else begin
      vld_q  <= act;
      idx_q  <= idx;
      last_q <= act && (idx == n_r - 1'b1);
      if (go) begin
        act <= 1'b1;
        idx <= '0;
        n_r <= AW'(n);
      end else if (act) begin
        if (idx == n_r - 1'b1) act <= 1'b0;
        else                   idx <= idx + 1'b1;
      end
    end
  end

  // byte 0 is the header, data starts at buffer slot 1
  assign rd_addr = idx + 1'b1;
  assign out_vld = vld_q;
  assign out_idx = idx_q;
  assign last    = last_q;

  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_idx < n_r));
  assert_go_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    go |-> !act);
endmodule

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier
  import aux_cls_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int CNT_W       = 5,
  parameter int POLL_CYCLES = 64,
  parameter int AW          = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rx_byte_vld,
  input  logic [7:0]       rx_byte,
  input  logic             st_done,
  input  logic             st_unplug,
  input  logic             st_tmo_live,
  input  logic             st_tmo_seen,
  input  logic             st_bad_stop,
  input  logic             st_no_edge,
  input  logic             st_bad_high,
  input  logic             st_bad_low,
  input  logic             st_min_viol,
  input  logic [CNT_W-1:0] st_rx_cnt,
  input  logic [CNT_W-1:0] cap_bytes,
  output logic             res_vld,
  output logic [2:0]       res_code,
  output logic [3:0]       reply_cmd,
  output logic [CNT_W-1:0] data_cnt,
  output logic             dout_vld,
  output logic [7:0]       dout_byte,
  output logic [AW-1:0]    dout_idx
);
  localparam int PW = $clog2(POLL_CYCLES + 1);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_SEND} st_e;

  st_e              st;
  logic [PW-1:0]    poll;
  logic [AW:0]      wptr;
  logic [3:0]       hdr_hi;
  aux_res_e         res_q;
  logic [3:0]       cmd_q;
  logic [CNT_W-1:0] dcnt_q;
  logic             vld_q;

  aux_res_e         j_res;
  logic [3:0]       j_code;
  logic [CNT_W-1:0] j_dcnt;
  logic             j_fwd;

  logic             wr_en, ev, go, snd_last;
  logic [AW-1:0]    rd_addr;

  assign wr_en = (st == S_BUSY) && rx_byte_vld && (wptr < FULL);
  assign ev    = (st == S_BUSY) &&
                 (st_unplug || st_done || poll == PW'(POLL_CYCLES - 1));
  assign go    = ev && j_fwd && (j_dcnt != '0);

  aux_rx_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk (clk),
    .we  (wr_en),
    .wa  (wptr[AW-1:0]),
    .wd  (rx_byte),
    .ra  (rd_addr),
    .rd  (dout_byte)
  );

  aux_status_judge #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_judge (
    .unplug (st_unplug),
    .done   (st_done),
    .tmo_a  (st_tmo_live),
    .tmo_b  (st_tmo_seen),
    .e_stop (st_bad_stop),
    .e_nodet(st_no_edge),
    .e_hi   (st_bad_high),
    .e_lo   (st_bad_low),
    .cnt    (st_rx_cnt),
    .hdr_hi (hdr_hi),
    .cap    (cap_bytes),
    .res    (j_res),
    .code   (j_code),
    .dcnt   (j_dcnt),
    .fwd    (j_fwd)
  );

  aux_byte_sender #(.AW(AW), .CNT_W(CNT_W)) u_send (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .n      (j_dcnt),
    .rd_addr(rd_addr),
    .out_vld(dout_vld),
    .out_idx(dout_idx),
    .last   (snd_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; poll <= '0; wptr <= '0; hdr_hi <= '0;
      res_q <= RES_OK; cmd_q <= '0; dcnt_q <= '0; vld_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_BUSY; poll <= '0; wptr <= '0; hdr_hi <= '0;
          res_q <= RES_OK; cmd_q <= '0; dcnt_q <= '0; vld_q <= 1'b0;
        end
        S_BUSY: begin
          poll <= poll + 1'b1;
          if (wr_en) begin
            wptr <= wptr + 1'b1;
            if (wptr == '0) hdr_hi <= rx_byte[7:4];
          end
          if (ev) begin
            res_q  <= j_res;
            cmd_q  <= j_code;
            dcnt_q <= j_dcnt;
            if (go) st <= S_SEND;
            else begin
              st    <= S_IDLE;
              vld_q <= 1'b1;
            end
          end
        end
        S_SEND: if (snd_last) begin
          st    <= S_IDLE;
          vld_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign res_vld   = vld_q;
  assign res_code  = res_q;
  assign reply_cmd = cmd_q;
  assign data_cnt  = dcnt_q;

  assert_unplug_first_R1: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUSY && st_unplug) |=> (res_vld && res_code == 3'd3));
  assert_window_expiry_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUSY && !st_unplug && !st_done && poll == PW'(POLL_CYCLES - 1))
      |=> (res_vld && res_code == 3'd1));
  assert_tmo_over_err_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUSY && st_done && !st_unplug && (st_tmo_live || st_tmo_seen))
      |=> (res_vld && res_code == 3'd1));
  assert_rx_err_invalid_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUSY && st_done && !st_unplug && !st_tmo_live && !st_tmo_seen &&
     (st_bad_stop || st_no_edge || st_bad_high || st_bad_low))
      |=> (res_vld && res_code == 3'd2));
  assert_minviol_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUSY && st_done && !st_unplug && !st_tmo_live && !st_tmo_seen &&
     !st_bad_stop && !st_no_edge && !st_bad_high && !st_bad_low &&
     st_rx_cnt != '0 && st_min_viol) |=> (res_code != 3'd2));
  assert_data_only_ack_R7: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> (reply_cmd == 4'd0 && res_code == 3'd0));
  assert_ovf_no_data_R8: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_code == 3'd4) |-> !dout_vld);
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !start) |=> (res_vld && $stable(res_code) &&
                              $stable(reply_cmd) && $stable(data_cnt)));
endmodule

// File: tb/aux_reply_classifier_tb.sv
module aux_reply_classifier_tb;
  localparam int DEPTH = 16;
  localparam int CNT_W = 5;
  localparam int POLL  = 64;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, rx_byte_vld = 0;
  logic [7:0] rx_byte = '0;
  logic st_done = 0, st_unplug = 0, st_tmo_live = 0, st_tmo_seen = 0;
  logic st_bad_stop = 0, st_no_edge = 0, st_bad_high = 0, st_bad_low = 0;
  logic st_min_viol = 0;
  logic [CNT_W-1:0] st_rx_cnt = '0, cap_bytes = '0;
  logic res_vld, dout_vld;
  logic [2:0] res_code;
  logic [3:0] reply_cmd;
  logic [CNT_W-1:0] data_cnt;
  logic [7:0] dout_byte;
  logic [AW-1:0] dout_idx;

  always #10 clk = ~clk;

  aux_reply_classifier #(.DEPTH(DEPTH), .CNT_W(CNT_W), .POLL_CYCLES(POLL)) u_dut (
    .clk, .rst, .start, .rx_byte_vld, .rx_byte, .st_done, .st_unplug,
    .st_tmo_live, .st_tmo_seen, .st_bad_stop, .st_no_edge, .st_bad_high,
    .st_bad_low, .st_min_viol, .st_rx_cnt, .cap_bytes, .res_vld, .res_code,
    .reply_cmd, .data_cnt, .dout_vld, .dout_byte, .dout_idx
  );

  typedef struct { int res; int code; int dc; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] exp_b[$];
  string      exp_bt[$];
  int n_chk = 0, n_fail = 0;
  logic prev_vld = 1'b0;
  int   out_n = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'(seed * 29 + i * 11 + 3);
  endfunction

  // monitor: compares replayed bytes and verdicts against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (dout_vld) begin
        if (exp_b.size() == 0) chk(0, "R7 unexpected byte", int'(dout_byte), -1);
        else begin
          automatic logic [7:0] e = exp_b.pop_front();
          automatic string t = exp_bt.pop_front();
          chk(dout_byte == e, {t, " byte"}, int'(dout_byte), int'(e));
          chk(int'(dout_idx) == out_n, {t, " idx"}, int'(dout_idx), out_n);
        end
        out_n++;
      end
      if (res_vld && !prev_vld) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected verdict", int'(res_code), -1);
        else begin
          automatic exp_t e = exp_q.pop_front();
          chk(int'(res_code) == e.res, {e.tag, " verdict"}, int'(res_code), e.res);
          chk(int'(reply_cmd) == e.code, {e.tag, " reply_cmd"}, int'(reply_cmd), e.code);
          chk(int'(data_cnt) == e.dc, {e.tag, " data_cnt"}, int'(data_cnt), e.dc);
          chk(exp_b.size() == 0, {e.tag, " missing bytes"}, exp_b.size(), 0);
          exp_b.delete(); exp_bt.delete();
        end
        out_n = 0;
      end
      prev_vld = res_vld;
    end
  end

  // driver: pushes expectations from the requirements, then stimulates
  task automatic txn(input int cnt, input logic [7:0] hdr, input int cap,
                     input bit unp, input bit dn, input bit ta, input bit tb,
                     input logic [3:0] errs, input bit mv, input int seed,
                     input string tag);
    exp_t e;
    int nb;
    e.tag = tag; e.code = 0; e.dc = 0;
    if (unp)                 e.res = 3;
    else if (!dn)            e.res = 1;
    else if (ta || tb)       e.res = 1;
    else if (errs != 4'd0)   e.res = 2;
    else if (cnt == 0)       e.res = 2;
    else begin
      e.code = int'(hdr[7:4]); e.dc = cnt - 1; e.res = 0;
      if (hdr[7:4] == 4'd0) begin
        if (e.dc > cap || e.dc > DEPTH - 1) e.res = 4;
        else for (int i = 1; i < cnt; i++) begin
          exp_b.push_back(pay(seed, i)); exp_bt.push_back(tag);
        end
      end
    end
    exp_q.push_back(e);
    nb = (cnt < DEPTH) ? cnt : DEPTH;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(res_vld == 1'b0, "R9 start clears res_vld", int'(res_vld), 0);
    for (int i = 0; i < nb; i++) begin
      rx_byte_vld = 1; rx_byte = (i == 0) ? hdr : pay(seed, i);
      @(negedge clk);
    end
    rx_byte_vld = 0;
    st_rx_cnt = CNT_W'(cnt); cap_bytes = CNT_W'(cap);
    st_done = dn; st_unplug = unp; st_tmo_live = ta; st_tmo_seen = tb;
    {st_bad_stop, st_no_edge, st_bad_high, st_bad_low} = errs;
    st_min_viol = mv;
    @(negedge clk);
    st_done = 0; st_unplug = 0; st_tmo_live = 0; st_tmo_seen = 0;
    {st_bad_stop, st_no_edge, st_bad_high, st_bad_low} = 4'd0; st_min_viol = 0;
    for (int w = 0; w < 300 && !res_vld; w++) @(negedge clk);
    if (!res_vld) chk(0, {tag, " no verdict"}, 0, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(res_vld == 0, "R10 res_vld", int'(res_vld), 0);
    chk(dout_vld == 0, "R10 dout_vld", int'(dout_vld), 0);
    chk(res_code == 0, "R10 res_code", int'(res_code), 0);
    // R5 R6 R7: acknowledged replies with data
    txn(5, 8'h00, 8, 0, 1, 0, 0, 4'd0, 0, 1, "R7 ack 4 bytes");
    txn(9, 8'h0A, 12, 0, 1, 0, 0, 4'd0, 0, 2, "R6 ack low nibble ignored");
    txn(1, 8'h00, 4, 0, 1, 0, 0, 4'd0, 0, 3, "R5 ack no data");
    // R7 nonzero commands carry no bytes
    txn(3, 8'h10, 8, 0, 1, 0, 0, 4'd0, 0, 4, "R7 nack");
    txn(2, 8'h25, 8, 0, 1, 0, 0, 4'd0, 0, 5, "R6 defer");
    txn(10, 8'h20, 1, 0, 1, 0, 0, 4'd0, 0, 6, "R8 nonack oversize");
    // R5 empty reply
    txn(0, 8'h00, 4, 0, 1, 0, 0, 4'd0, 0, 7, "R5 zero count");
    // R4 each receive error, and the ignored flag
    txn(3, 8'h00, 4, 0, 1, 0, 0, 4'b1000, 0, 8, "R4 bad stop");
    txn(3, 8'h00, 4, 0, 1, 0, 0, 4'b0100, 0, 9, "R4 no edge");
    txn(3, 8'h00, 4, 0, 1, 0, 0, 4'b0010, 0, 10, "R4 bad high");
    txn(3, 8'h00, 4, 0, 1, 0, 0, 4'b0001, 0, 11, "R4 bad low");
    txn(3, 8'h00, 4, 0, 1, 0, 0, 4'd0, 1, 12, "R4 min viol ignored");
    // R3 timeout flags beat receive errors
    txn(3, 8'h00, 4, 0, 1, 1, 0, 4'b1111, 0, 13, "R3 tmo live");
    txn(3, 8'h00, 4, 0, 1, 0, 1, 4'b0101, 0, 14, "R3 tmo seen");
    // R1 unplug beats everything
    txn(3, 8'h00, 4, 1, 1, 1, 1, 4'b1111, 0, 15, "R1 unplug with done");
    txn(3, 8'h00, 4, 1, 0, 0, 0, 4'd0, 0, 16, "R1 unplug alone");
    // R2 no completion within the poll window
    txn(3, 8'h00, 4, 0, 0, 0, 0, 4'd0, 0, 17, "R2 window expiry");
    // R8 caller size and buffer depth limits
    txn(4, 8'h00, 3, 0, 1, 0, 0, 4'd0, 0, 18, "R8 exact fit");
    txn(5, 8'h00, 3, 0, 1, 0, 0, 4'd0, 0, 19, "R8 one over cap");
    txn(20, 8'h00, 31, 0, 1, 0, 0, 4'd0, 0, 20, "R8 over depth");
    txn(16, 8'h00, 15, 0, 1, 0, 0, 4'd0, 0, 21, "R8 full depth");
    // R9 verdict holds while no start arrives
    begin
      automatic logic [2:0] r0 = res_code;
      automatic logic [CNT_W-1:0] d0 = data_cnt;
      repeat (6) @(negedge clk);
      chk(res_vld == 1 && res_code == r0, "R9 verdict held", int'(res_code), int'(r0));
      chk(data_cnt == d0, "R9 data_cnt held", int'(data_cnt), int'(d0));
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all verdicts seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule